// File: doc/BRIEF.md
# Registered Operand Forwarding Unit

This block resolves read-after-write hazards for the two source operands of an in-order five-stage RV32 integer pipeline. During the decode cycle it compares each source register index against the destinations of the instructions currently in execute and in memory. It then chooses the youngest matching result, or the register file read data when nothing matches. The chosen value is written into the decode-to-execute operand register at the closing clock edge. The execute stage therefore reads its operands straight from a flop, and no selection logic sits in front of the ALU.

A stall input comes from a multi-cycle execute unit. While it is high, the instruction waiting in decode does not advance: the destination index and write-enable captured for execute hold their values. The operand registers, however, keep sampling the bypass every cycle. When the long operation finally raises its write enable with a valid result, the waiting operand picks that result up without any extra cycle. A flush input turns the next execute slot into a bubble that writes no register.

Top module: `fwd_unit`

## Requirements
- R1: While reset is high, both operand outputs are zero and the execute-stage write enable and destination index outputs are zero at the following clock edge.
- R2: When a source index is non-zero and matches no active producer, the operand register captures the register file read data for that source one clock later.
- R3: When the execute-stage producer has its write enable set and its destination equals a non-zero source index, that operand register captures the execute result one clock later.
- R4: When only the memory-stage producer writes a non-zero source index, that operand register captures the memory-stage result one clock later.
- R5: When both producers write the same register that a source names, the execute-stage result (the younger instruction) is captured.
- R6: A source index of zero always yields an operand of zero, even when a producer targets register 0 or the register file read data is non-zero.
- R7: While stall is high and flush is low, the execute-stage write enable and destination outputs keep their values, and the operand registers still capture the current bypass selection every cycle.
- R8: While flush is high, the next clock loads zero into both operands, the write enable and the destination index, whatever the value of stall.
- R9: The two operands are resolved independently: one source can be forwarded while the other takes the register file data in the same cycle.
- R10: With stall and flush low, the execute-stage write enable and destination outputs take the decode-stage values one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Multi-cycle execute unit busy; decode instruction holds |
| flush_i | input | 1 | Insert a bubble into the execute stage |
| dec_rs1_i | input | AW | Decode-stage first source index |
| dec_rs2_i | input | AW | Decode-stage second source index |
| rf_rd1_i | input | XLEN | Register file data for first source |
| rf_rd2_i | input | XLEN | Register file data for second source |
| dec_we_i | input | 1 | Decode instruction writes a register |
| dec_rd_i | input | AW | Decode instruction destination index |
| ex_we_i | input | 1 | Execute-stage result valid and written back |
| ex_rd_i | input | AW | Execute-stage destination index |
| ex_res_i | input | XLEN | Execute-stage result |
| mem_we_i | input | 1 | Memory-stage result valid and written back |
| mem_rd_i | input | AW | Memory-stage destination index |
| mem_res_i | input | XLEN | Memory-stage result |
| op_a_o | output | XLEN | Registered first operand for execute |
| op_b_o | output | XLEN | Registered second operand for execute |
| ex_we_o | output | 1 | Registered write enable for execute |
| ex_rd_o | output | AW | Registered destination index for execute |

AW is $clog2(NREGS).

## Verification
Two functions can fall on the same edge: a stall can hold the destination registers while the bypass picks up a result that has just become valid, and a flush can meet a stall together with live forwarding hits. The bench first holds stall high for several cycles with the producer disabled. It then raises the execute write enable on the waited-for register. At each step it checks that the operand switches to the new result while the destination outputs stay frozen. In a second test it asserts flush and stall together with both producers matching, and it expects all-zero outputs, which shows that flush wins over both the hold and the forwarding.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Source chosen for one operand
    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_RF   = 2'd1,
        SRC_EX   = 2'd2,
        SRC_MEM  = 2'd3
    } fwd_src_e;

    localparam int unsigned NUM_OPS = 2;

    // Producer hit test on an index of arbitrary width, passed as ints
    function automatic logic prod_hit(input logic we, input int unsigned rd, input int unsigned rs);
        return we && (rd == rs) && (rs != 0);
    endfunction

endpackage

// File: rtl/fwd_sel.sv
module fwd_sel
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned AW   = 5
) (
    input  logic [AW-1:0]   rs_i,
    input  logic [XLEN-1:0] rf_i,
    input  logic            ex_we_i,
    input  logic [AW-1:0]   ex_rd_i,
    input  logic [XLEN-1:0] ex_res_i,
    input  logic            mem_we_i,
    input  logic [AW-1:0]   mem_rd_i,
    input  logic [XLEN-1:0] mem_res_i,
    output fwd_src_e        src_o,
    output logic [XLEN-1:0] val_o
);

    always_comb begin
        if (rs_i == '0)
            src_o = SRC_ZERO;
        else if (prod_hit(ex_we_i, int'(ex_rd_i), int'(rs_i)))
            src_o = SRC_EX;
        else if (prod_hit(mem_we_i, int'(mem_rd_i), int'(rs_i)))
            src_o = SRC_MEM;
        else
            src_o = SRC_RF;
    end

    always_comb begin
        unique case (src_o)
            SRC_ZERO: val_o = '0;
            SRC_EX:   val_o = ex_res_i;
            SRC_MEM:  val_o = mem_res_i;
            default:  val_o = rf_i;
        endcase
    end

endmodule

// File: rtl/fwd_opreg.sv
module fwd_opreg #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush_i,
    input  logic [XLEN-1:0] d_i,
    output logic [XLEN-1:0] q_o
);

    // Loads every cycle so a waiting instruction keeps tracking the bypass
    always_ff @(posedge clk) begin
        if (rst || flush_i)
            q_o <= '0;
        else
            q_o <= d_i;
    end

endmodule

// File: rtl/fwd_meta.sv
module fwd_meta #(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall_i,
    input  logic          flush_i,
    input  logic          dec_we_i,
    input  logic [AW-1:0] dec_rd_i,
    output logic          ex_we_o,
    output logic [AW-1:0] ex_rd_o
);

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            ex_we_o <= 1'b0;
            ex_rd_o <= '0;
        end else if (!stall_i) begin
            ex_we_o <= dec_we_i;
            ex_rd_o <= dec_rd_i;
        end
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 32,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall_i,
    input  logic            flush_i,
    input  logic [AW-1:0]   dec_rs1_i,
    input  logic [AW-1:0]   dec_rs2_i,
    input  logic [XLEN-1:0] rf_rd1_i,
    input  logic [XLEN-1:0] rf_rd2_i,
    input  logic            dec_we_i,
    input  logic [AW-1:0]   dec_rd_i,
    input  logic            ex_we_i,
    input  logic [AW-1:0]   ex_rd_i,
    input  logic [XLEN-1:0] ex_res_i,
    input  logic            mem_we_i,
    input  logic [AW-1:0]   mem_rd_i,
    input  logic [XLEN-1:0] mem_res_i,
    output logic [XLEN-1:0] op_a_o,
    output logic [XLEN-1:0] op_b_o,
    output logic            ex_we_o,
    output logic [AW-1:0]   ex_rd_o
);

    logic [NUM_OPS-1:0][AW-1:0]   rs_idx;
    logic [NUM_OPS-1:0][XLEN-1:0] rf_val;
    logic [NUM_OPS-1:0][XLEN-1:0] sel_val;
    logic [NUM_OPS-1:0][XLEN-1:0] op_q;
    fwd_src_e                     sel_src [NUM_OPS];

    assign rs_idx[0] = dec_rs1_i;
    assign rs_idx[1] = dec_rs2_i;
    assign rf_val[0] = rf_rd1_i;
    assign rf_val[1] = rf_rd2_i;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_sel #(.XLEN(XLEN), .AW(AW)) u_sel (
            .rs_i      (rs_idx[g]),
            .rf_i      (rf_val[g]),
            .ex_we_i   (ex_we_i),
            .ex_rd_i   (ex_rd_i),
            .ex_res_i  (ex_res_i),
            .mem_we_i  (mem_we_i),
            .mem_rd_i  (mem_rd_i),
            .mem_res_i (mem_res_i),
            .src_o     (sel_src[g]),
            .val_o     (sel_val[g])
        );

        fwd_opreg #(.XLEN(XLEN)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .flush_i (flush_i),
            .d_i     (sel_val[g]),
            .q_o     (op_q[g])
        );
    end

    assign op_a_o = op_q[0];
    assign op_b_o = op_q[1];

    fwd_meta #(.AW(AW)) u_meta (
        .clk      (clk),
        .rst      (rst),
        .stall_i  (stall_i),
        .flush_i  (flush_i),
        .dec_we_i (dec_we_i),
        .dec_rd_i (dec_rd_i),
        .ex_we_o  (ex_we_o),
        .ex_rd_o  (ex_rd_o)
    );

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 32,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input logic            clk,
    input logic            rst,
    input logic            stall_i,
    input logic            flush_i,
    input logic [AW-1:0]   dec_rs1_i,
    input logic [AW-1:0]   dec_rs2_i,
    input logic [XLEN-1:0] rf_rd1_i,
    input logic [XLEN-1:0] rf_rd2_i,
    input logic            dec_we_i,
    input logic [AW-1:0]   dec_rd_i,
    input logic            ex_we_i,
    input logic [AW-1:0]   ex_rd_i,
    input logic [XLEN-1:0] ex_res_i,
    input logic            mem_we_i,
    input logic [AW-1:0]   mem_rd_i,
    input logic [XLEN-1:0] mem_res_i,
    input logic [XLEN-1:0] op_a_o,
    input logic [XLEN-1:0] op_b_o,
    input logic            ex_we_o,
    input logic [AW-1:0]   ex_rd_o
);

    logic a_ex_hit, a_mem_hit, b_ex_hit, b_mem_hit;
    assign a_ex_hit  = ex_we_i  && (ex_rd_i  == dec_rs1_i) && (dec_rs1_i != '0);
    assign a_mem_hit = mem_we_i && (mem_rd_i == dec_rs1_i) && (dec_rs1_i != '0);
    assign b_ex_hit  = ex_we_i  && (ex_rd_i  == dec_rs2_i) && (dec_rs2_i != '0);
    assign b_mem_hit = mem_we_i && (mem_rd_i == dec_rs2_i) && (dec_rs2_i != '0);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (op_a_o == '0 && op_b_o == '0 && !ex_we_o && ex_rd_o == '0));

    p_rf_path_r2: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && dec_rs1_i != '0 && !a_ex_hit && !a_mem_hit) |=> op_a_o == $past(rf_rd1_i));

    p_ex_fwd_r3: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && b_ex_hit) |=> op_b_o == $past(ex_res_i));

    p_mem_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && a_mem_hit && !a_ex_hit) |=> op_a_o == $past(mem_res_i));

    p_young_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && a_ex_hit && a_mem_hit) |=> op_a_o == $past(ex_res_i));

    p_x0_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_rs2_i == '0) |=> op_b_o == '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !flush_i) |=> ($stable(ex_we_o) && $stable(ex_rd_o)));

    p_bubble_r8: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (!ex_we_o && ex_rd_o == '0 && op_a_o == '0 && op_b_o == '0));

    p_advance_r10: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !flush_i) |=> (ex_we_o == $past(dec_we_i) && ex_rd_o == $past(dec_rd_i)));

endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .NREGS(NREGS)) u_chk (.*);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
    localparam int unsigned XLEN  = 32;
    localparam int unsigned NREGS = 32;
    localparam int unsigned AW    = $clog2(NREGS);

    logic            clk = 1'b0;
    logic            rst;
    logic            stall_i, flush_i;
    logic [AW-1:0]   dec_rs1_i, dec_rs2_i, dec_rd_i, ex_rd_i, mem_rd_i;
    logic [XLEN-1:0] rf_rd1_i, rf_rd2_i, ex_res_i, mem_res_i;
    logic            dec_we_i, ex_we_i, mem_we_i;
    logic [XLEN-1:0] op_a_o, op_b_o;
    logic            ex_we_o;
    logic [AW-1:0]   ex_rd_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    fwd_unit #(.XLEN(XLEN), .NREGS(NREGS)) u_dut (.*);

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        stall_i = 0; flush_i = 0;
        dec_rs1_i = 0; dec_rs2_i = 0; dec_rd_i = 0; dec_we_i = 0;
        rf_rd1_i = 0; rf_rd2_i = 0;
        ex_we_i = 0; ex_rd_i = 0; ex_res_i = 0;
        mem_we_i = 0; mem_rd_i = 0; mem_res_i = 0;
    endtask

    // inputs change on negedge; one posedge later the result is sampled on negedge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        idle();
        rst = 1; dec_rs1_i = 5; rf_rd1_i = 32'hDEAD_0001; dec_we_i = 1; dec_rd_i = 4;
        step(); step();
        chk("R1 op_a", op_a_o, 0);
        chk("R1 op_b", op_b_o, 0);
        chk("R1 we", {31'd0, ex_we_o}, 0);
        chk("R1 rd", {27'd0, ex_rd_o}, 0);
        rst = 0; idle();
        step();
    endtask

    task automatic t_rf();
        idle();
        dec_rs1_i = 5; dec_rs2_i = 6; rf_rd1_i = 32'h11; rf_rd2_i = 32'h22;
        ex_rd_i = 5; ex_res_i = 32'hBAD; ex_we_i = 0;   // matching index but not writing
        step();
        chk("R2 rf a", op_a_o, 32'h11);
        chk("R2 rf b", op_b_o, 32'h22);
    endtask

    task automatic t_ex();
        idle();
        dec_rs1_i = 5; dec_rs2_i = 6; rf_rd1_i = 32'h1; rf_rd2_i = 32'h66;
        ex_we_i = 1; ex_rd_i = 5; ex_res_i = 32'hA5A5_0005;
        step();
        chk("R3 ex fwd a", op_a_o, 32'hA5A5_0005);
        chk("R9 other from rf", op_b_o, 32'h66);
    endtask

    task automatic t_mem();
        idle();
        dec_rs1_i = 8; dec_rs2_i = 9; rf_rd1_i = 32'h88; rf_rd2_i = 32'h2;
        mem_we_i = 1; mem_rd_i = 9; mem_res_i = 32'hC0DE_0009;
        step();
        chk("R4 mem fwd b", op_b_o, 32'hC0DE_0009);
        chk("R9 a from rf", op_a_o, 32'h88);
    endtask

    task automatic t_prio();
        idle();
        dec_rs1_i = 7; dec_rs2_i = 7; rf_rd1_i = 32'h3; rf_rd2_i = 32'h3;
        ex_we_i = 1; ex_rd_i = 7; ex_res_i = 32'hEEEE_0007;
        mem_we_i = 1; mem_rd_i = 7; mem_res_i = 32'h4444_0007;
        step();
        chk("R5 ex over mem a", op_a_o, 32'hEEEE_0007);
        chk("R5 ex over mem b", op_b_o, 32'hEEEE_0007);
    endtask

    task automatic t_zero();
        idle();
        dec_rs1_i = 0; dec_rs2_i = 0; rf_rd1_i = 32'hFFFF_FFFF; rf_rd2_i = 32'h1234;
        ex_we_i = 1; ex_rd_i = 0; ex_res_i = 32'h77;
        mem_we_i = 1; mem_rd_i = 0; mem_res_i = 32'h99;
        step();
        chk("R6 x0 a", op_a_o, 0);
        chk("R6 x0 b", op_b_o, 0);
    endtask

    task automatic t_stall();
        idle();
        dec_we_i = 1; dec_rd_i = 3;
        step();
        chk("R10 we follows", {31'd0, ex_we_o}, 1);
        chk("R10 rd follows", {27'd0, ex_rd_o}, 3);
        // long op in execute, next instruction waits on x4
        stall_i = 1; dec_we_i = 0; dec_rd_i = 9; dec_rs1_i = 4; rf_rd1_i = 32'h44;
        step();
        chk("R7 operand tracks rf", op_a_o, 32'h44);
        chk("R7 rd held", {27'd0, ex_rd_o}, 3);
        step();
        chk("R7 we held", {31'd0, ex_we_o}, 1);
        ex_we_i = 1; ex_rd_i = 4; ex_res_i = 32'h9999_0004;
        step();
        chk("R7 picks up result", op_a_o, 32'h9999_0004);
        chk("R7 rd still held", {27'd0, ex_rd_o}, 3);
        stall_i = 0; ex_we_i = 0; mem_we_i = 1; mem_rd_i = 4; mem_res_i = 32'h9999_0004;
        step();
        chk("R10 rd on release", {27'd0, ex_rd_o}, 9);
        chk("R10 we on release", {31'd0, ex_we_o}, 0);
        chk("R4 result now from mem", op_a_o, 32'h9999_0004);
    endtask

    task automatic t_flush();
        idle();
        dec_we_i = 1; dec_rd_i = 12; dec_rs1_i = 2; dec_rs2_i = 3;
        rf_rd1_i = 32'h21; rf_rd2_i = 32'h31;
        step();
        chk("R10 pre-flush rd", {27'd0, ex_rd_o}, 12);
        flush_i = 1; stall_i = 1;
        ex_we_i = 1; ex_rd_i = 2; ex_res_i = 32'h5;
        mem_we_i = 1; mem_rd_i = 3; mem_res_i = 32'h6;
        step();
        chk("R8 op_a zero", op_a_o, 0);
        chk("R8 op_b zero", op_b_o, 0);
        chk("R8 we zero", {31'd0, ex_we_o}, 0);
        chk("R8 rd zero", {27'd0, ex_rd_o}, 0);
        idle();
        step();
    endtask

    initial begin
        idle();
        rst = 1;
        step();
        t_reset();
        t_rf();
        t_ex();
        t_mem();
        t_prio();
        t_zero();
        t_stall();
        t_flush();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule